// File: doc/BRIEF.md
# Zero-Suppressed Double-Column Serial Readout

After an acquisition window closes, this block turns the frozen contents of one double column of pixels into a single serial bitstream. The column holds 128 pixels, arranged as eight superpixels of sixteen pixels each. Every pixel carries a hit flag and an 8-bit payload. The stream always contains the flag of each pixel. The payload follows the flag only when the flag is set. A flag-controlled multiplexer skips the payload of an empty pixel, so that pixel costs one bit instead of nine.

A one-cycle start strobe begins a readout. The block samples the whole pixel array on that edge, so the array may change afterwards without disturbing the stream. From the next cycle on, it shifts out one bit per clock with a valid strobe, in a fixed order. After the last bit it raises a one-cycle completion pulse and then returns to idle, where it accepts the next start.

Top module: `colro_top`

## Requirements
- R1: After synchronous reset, `ser_valid`, `ser_bit` and `done` are all 0 and no bits are emitted until a start is accepted.
- R2: Pixels are emitted in order of global index g = 16*superpixel + pixel, from 0 to 127. Pixel g's flag is `hit_flags[g]` and its payload is `pix_data[8g+7:8g]`. Each pixel's flag bit comes first.
- R3: A pixel whose flag is 1 emits the bit 1, then its 8 payload bits, most significant bit first.
- R4: A pixel whose flag is 0 emits only the bit 0, and its payload never appears in the stream.
- R5: The valid bits form one unbroken run that starts in the cycle after the start strobe is sampled. The run is exactly 128 + 8*H bits long, where H is the number of set flags.
- R6: `done` is high for exactly one cycle, the cycle right after the last valid bit. `ser_valid` is low in that cycle.
- R7: A start strobe that arrives while a readout is in progress, including the done cycle, is ignored. The running stream continues unchanged and no second stream follows.
- R8: The flags and payloads are captured on the accepting edge. Changes to `hit_flags` or `pix_data` during a readout do not affect the emitted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Readout start strobe, sampled at the rising edge |
| hit_flags | input | 128 | Hit flag of each pixel, bit g for pixel g |
| pix_data | input | 1024 | Payload of each pixel, 8 bits per pixel, pixel g in bits 8g+7:8g |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | High when `ser_bit` carries a stream bit |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
A wrong pixel index or bit counter shows up as a wrong bit at a known position in the stream. It appears within nine cycles of the faulty step, and the bench compares every stream bit against a model built from the inputs. A skip decision that goes the wrong way changes the stream length by exactly eight bits, so the length check catches it. A stuck or misrouted state shows up as a gap in the valid run, as a done pulse in the wrong cycle or of the wrong width, or as a restarted stream. Separate directed cases cover a start strobe during a readout and input changes during a readout.

// File: rtl/colro_pkg.sv
package colro_pkg;
    localparam int SPX_N   = 8;
    localparam int SPX_PIX = 16;
    localparam int DATA_W  = 8;
    localparam int PIX_N   = SPX_N * SPX_PIX;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] data;
    } pix_word_t;

    function automatic int stream_len(input int hits);
        return PIX_N + hits * DATA_W;
    endfunction
endpackage

// File: rtl/colro_snapshot.sv
module colro_snapshot
    import colro_pkg::*;
#(
    parameter int NPIX = PIX_N
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [NPIX-1:0]          hit_flags,
    input  logic [NPIX*DATA_W-1:0]   pix_data,
    output pix_word_t [NPIX-1:0]     words
);
    for (genvar g = 0; g < NPIX; g++) begin : g_pix
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (load) begin
                words[g].flag <= hit_flags[g];
                words[g].data <= pix_data[g*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/colro_pix_mux.sv
module colro_pix_mux
    import colro_pkg::*;
#(
    parameter int NSPX  = SPX_N,
    parameter int NSUB  = SPX_PIX,
    localparam int NPIX  = NSPX * NSUB,
    localparam int IDX_W = $clog2(NPIX),
    localparam int SUB_W = $clog2(NSUB)
) (
    input  pix_word_t [NPIX-1:0] words,
    input  logic [IDX_W-1:0]     idx,
    output pix_word_t            cur
);
    pix_word_t spx_pick [NSPX];

    for (genvar s = 0; s < NSPX; s++) begin : g_spx
        always_comb begin
            spx_pick[s] = words[s*NSUB + int'(idx[SUB_W-1:0])];
        end
    end

    always_comb begin
        cur = spx_pick[idx[IDX_W-1:SUB_W]];
    end
endmodule

// File: rtl/colro_seq.sv
module colro_seq
    import colro_pkg::*;
#(
    parameter int NPIX   = PIX_N,
    localparam int IDX_W = $clog2(NPIX),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  pix_word_t        cur,
    output logic [IDX_W-1:0] idx,
    output logic             load,
    output logic             ser_bit,
    output logic             ser_valid,
    output logic             done
);
    rd_state_e        state;
    logic [BIT_W-1:0] bitcnt;
    logic             last_pix;

    assign last_pix = (idx == IDX_W'(NPIX - 1));
    assign load     = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_FLAG;
                    idx   <= '0;
                end
                ST_FLAG: begin
                    if (cur.flag) begin
                        state  <= ST_DATA;
                        bitcnt <= BIT_W'(DATA_W - 1);
                    end else if (last_pix) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bitcnt == '0) begin
                        if (last_pix) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_FLAG;
                            idx   <= idx + 1'b1;
                        end
                    end else begin
                        bitcnt <= bitcnt - 1'b1;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ser_valid = (state == ST_FLAG) || (state == ST_DATA);
        done      = (state == ST_DONE);
        unique case (state)
            ST_FLAG: ser_bit = cur.flag;
            ST_DATA: ser_bit = cur.data[bitcnt];
            default: ser_bit = 1'b0;
        endcase
    end

    // R4: an empty pixel never enters the payload phase
    a_r4_empty_skip: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLAG && !cur.flag) |=> (state != ST_DATA));

    // R3: the payload phase runs through all bits before leaving
    a_r3_payload_run: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && bitcnt != '0) |=> (state == ST_DATA));

    // R5: the valid run only ends into the done cycle
    a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_valid) |-> done);

    // R6: done lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done never coincides with a valid bit
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !ser_valid);

    // R7: a start while busy never resets the pixel index to zero mid-run
    a_r7_busy_start: assert property (@(posedge clk) disable iff (rst)
        (start && state == ST_DATA && bitcnt != '0) |=> $stable(idx));
endmodule

// File: rtl/colro_top.sv
module colro_top
    import colro_pkg::*;
#(
    parameter int NSPX = SPX_N,
    parameter int NSUB = SPX_PIX,
    localparam int NPIX  = NSPX * NSUB,
    localparam int IDX_W = $clog2(NPIX)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [NPIX-1:0]        hit_flags,
    input  logic [NPIX*DATA_W-1:0] pix_data,
    output logic                   ser_bit,
    output logic                   ser_valid,
    output logic                   done
);
    pix_word_t [NPIX-1:0] words;
    pix_word_t            cur;
    logic [IDX_W-1:0]     idx;
    logic                 load;

    colro_snapshot #(.NPIX(NPIX)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .hit_flags (hit_flags),
        .pix_data  (pix_data),
        .words     (words)
    );

    colro_pix_mux #(.NSPX(NSPX), .NSUB(NSUB)) u_mux (
        .words (words),
        .idx   (idx),
        .cur   (cur)
    );

    colro_seq #(.NPIX(NPIX)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cur       (cur),
        .idx       (idx),
        .load      (load),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .done      (done)
    );

    // R1: nothing is emitted in the cycle right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ser_valid && !done && !ser_bit));
endmodule

// File: tb/colro_top_tb.sv
`timescale 1ns/1ps
module colro_top_tb;
    import colro_pkg::*;

    localparam int NPIX = PIX_N;
    localparam int MAXB = NPIX * (DATA_W + 1);

    typedef struct packed {
        int pat;
        int seed;
        int exp_len;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{0, 5,   128},
        '{1, 17,  1152},
        '{2, 99,  640},
        '{3, 3,   144},
        '{4, 200, 256},
        '{5, 71,  472}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NPIX-1:0]        hit_flags = '0;
    logic [NPIX*DATA_W-1:0] pix_data = '0;
    logic ser_bit, ser_valid, done;

    int n_checks = 0;
    int n_fail = 0;
    bit exp_bits [MAXB];
    int exp_len;

    always #2 clk = ~clk;

    colro_top u_dut (
        .clk(clk), .rst(rst), .start(start),
        .hit_flags(hit_flags), .pix_data(pix_data),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .done(done)
    );

    function automatic bit flag_of(int pat, int p);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return (p % 2) == 1;
            3: return (p == 0) || (p == NPIX - 1);
            4: return (p >= 16) && (p < 32);
            default: return (p % 3) == 0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(int pat, int seed);
        int hits = 0;
        exp_len = 0;
        for (int p = 0; p < NPIX; p++) begin
            logic [7:0] d = 8'((p * 37 + seed) & 255);
            hit_flags[p] = flag_of(pat, p);
            pix_data[p*DATA_W +: DATA_W] = d;
            exp_bits[exp_len] = hit_flags[p];
            exp_len++;
            if (hit_flags[p]) begin
                hits++;
                for (int b = DATA_W - 1; b >= 0; b--) begin
                    exp_bits[exp_len] = d[b];
                    exp_len++;
                end
            end
        end
        check(exp_len == stream_len(hits), "R5 model", exp_len, stream_len(hits));
    endtask

    task automatic run(int poke_at, int scr_at, int want_len);
        int  got = 0;
        int  bad = 0;
        int  first_bad = -1;
        int  cyc = 0;
        int  dones = 0;
        bit  lowseen = 0;
        bit  gap = 0;
        bit  done_ok = 0;
        bit  prev_v = 0;
        bit  seen_done = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!seen_done && cyc < 3000) begin
            if (ser_valid) begin
                if (lowseen) gap = 1;
                if (got < exp_len && ser_bit != exp_bits[got]) begin
                    bad++;
                    if (first_bad < 0) first_bad = got;
                end
                got++;
            end else if (!done) begin
                lowseen = 1;
            end
            if (done) begin
                seen_done = 1;
                dones++;
                done_ok = prev_v && !ser_valid;
            end
            prev_v = ser_valid;
            start = (cyc == poke_at);
            if (cyc == scr_at) begin
                hit_flags = ~hit_flags;
                pix_data  = ~pix_data;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done_ok && !done, "R6 done timing", int'(done), 0);
        check(got == want_len && got == exp_len, "R5 length", got, want_len);
        check(!gap, "R5 contiguous", int'(gap), 0);
        check(bad == 0, "R2/R3/R4 content first-bad-index", first_bad, -1);
        // R7: no second stream after a start seen while busy
        repeat (3) begin
            @(negedge clk);
            if (ser_valid || done) dones++;
        end
        check(dones == 1, "R7 no restart", dones, 1);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset, before any start
        repeat (4) begin
            @(negedge clk);
            check(!ser_valid && !done && !ser_bit, "R1 reset state",
                  int'({ser_valid, done, ser_bit}), 0);
        end
        foreach (VECS[i]) begin
            setup(VECS[i].pat, VECS[i].seed);
            run(-1, -1, VECS[i].exp_len);
        end
        // R7: start pulses during the payload run and in the done cycle
        setup(2, 11);
        run(50, -1, 640);
        setup(1, 7);
        run(1152, -1, 1152);
        // R8: inputs inverted mid-stream; stream follows the captured values
        setup(5, 33);
        run(-1, 30, 472);
        setup(3, 1);
        run(-1, 0, 144);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule